// File: doc/BRIEF.md
# Overscan Border Window Generator

This block sits in a display output pipeline next to the scaler. For every raster position it receives, it decides whether the pixel falls inside the scaled output rectangle or in the overscan border around it. The host programs the active display size and the rectangle's origin and size. From these the block derives the four border widths. The right and bottom widths are computed from what is left of the active area, are clamped at zero, and can be widened by a two-pixel debug margin.

For a border pixel, the block either flags a constant fill and presents the programmed 24-bit RGB border colour, or it presents the coordinate of the nearest pixel on the rectangle's edge. A downstream line buffer can then fetch that edge sample and repeat it. The pixel decision is registered in a single pipeline stage.

The block also turns a requested source viewport into luma and chroma viewports for the plane fetchers. The luma viewport is rounded down to even values. The chroma viewport is half of the luma viewport for 4:2:0 input and equal to it for any other input. A plane's viewport is taken on a load strobe only when its width and height are both nonzero.

Top module: `overscan_window`

## Requirements
- R1: The left border output equals the rectangle x offset and the top border output equals the rectangle y offset, combinationally.
- R2: The right border equals active width minus rectangle x minus rectangle width. The bottom border equals active height minus rectangle y minus rectangle height.
- R3: A right or bottom border that would be negative is output as 0, and the inside test then extends to the active edge.
- R4: With `dbg_margin`=1, 2 is added to both the right and bottom borders before clamping.
- R5: One cycle after an input pixel, `o_valid` equals the `in_valid` of that pixel. `o_inside`=1 exactly when left ≤ x < act_w − right and top ≤ y < act_h − bottom.
- R6: With `edge_mode`=0, a border pixel gives `o_fill_const`=1 and `o_rgb`=`border_rgb`. An inside pixel gives `o_fill_const`=0 and `o_rgb`=0.
- R7: `o_src_x`/`o_src_y` carry the raster position clamped into the rectangle: equal to x,y inside, and the nearest edge column/row outside. With `edge_mode`=1, `o_fill_const` is 0.
- R8: On `vp_load`, the luma viewport x, y, width and height are the requested values with bit 0 cleared.
- R9: With `fmt420`=1, each chroma viewport field is the luma field shifted right by one. With `fmt420`=0, each chroma field equals the luma field.
- R10: A `vp_load` whose plane width or height is zero leaves that plane's viewport outputs unchanged.
- R11: After reset, `o_valid`, `o_inside`, `o_fill_const`, `o_rgb` and all viewport outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_w | input | W | Active display width |
| act_h | input | W | Active display height |
| rect_x | input | W | Output rectangle x offset |
| rect_y | input | W | Output rectangle y offset |
| rect_w | input | W | Output rectangle width |
| rect_h | input | W | Output rectangle height |
| dbg_margin | input | 1 | Adds 2 to right and bottom borders |
| edge_mode | input | 1 | 1 = repeat edge pixel, 0 = constant colour |
| border_rgb | input | CW | Border colour |
| in_valid | input | 1 | Pixel position is active |
| pix_x | input | W | Pixel column |
| pix_y | input | W | Pixel line |
| vp_load | input | 1 | Take viewport request |
| fmt420 | input | 1 | Source is 4:2:0 |
| vp_x | input | W | Requested viewport x |
| vp_y | input | W | Requested viewport y |
| vp_w | input | W | Requested viewport width |
| vp_h | input | W | Requested viewport height |
| brd_left | output | W+1 | Left border width |
| brd_right | output | W+1 | Right border width |
| brd_top | output | W+1 | Top border width |
| brd_bottom | output | W+1 | Bottom border width |
| o_valid | output | 1 | Registered pixel valid |
| o_inside | output | 1 | Pixel inside rectangle |
| o_fill_const | output | 1 | Use constant border colour |
| o_rgb | output | CW | Border colour or 0 |
| o_src_x | output | W | Clamped rectangle column |
| o_src_y | output | W | Clamped rectangle row |
| luma_x | output | W | Luma viewport x |
| luma_y | output | W | Luma viewport y |
| luma_w | output | W | Luma viewport width |
| luma_h | output | W | Luma viewport height |
| chroma_x | output | W | Chroma viewport x |
| chroma_y | output | W | Chroma viewport y |
| chroma_w | output | W | Chroma viewport width |
| chroma_h | output | W | Chroma viewport height |

## Verification
The bench builds the block with W=12 and CW=24. A 100x80 active area then fits, and the signed border arithmetic, the clamp to zero and the two-pixel margin can all be driven to their boundaries with small coordinates. Pixels sit exactly on and one past each rectangle edge and at the far corner, so both fill modes and the edge clamping are observed. Odd viewport requests in both formats, followed by a zero-width request, cover rounding, halving and the ignored load.

// File: rtl/overscan_window.sv
module overscan_window #(
  parameter int W  = 12,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  act_w,
  input  logic [W-1:0]  act_h,
  input  logic [W-1:0]  rect_x,
  input  logic [W-1:0]  rect_y,
  input  logic [W-1:0]  rect_w,
  input  logic [W-1:0]  rect_h,
  input  logic          dbg_margin,
  input  logic          edge_mode,
  input  logic [CW-1:0] border_rgb,
  input  logic          in_valid,
  input  logic [W-1:0]  pix_x,
  input  logic [W-1:0]  pix_y,
  input  logic          vp_load,
  input  logic          fmt420,
  input  logic [W-1:0]  vp_x,
  input  logic [W-1:0]  vp_y,
  input  logic [W-1:0]  vp_w,
  input  logic [W-1:0]  vp_h,
  output logic [W:0]    brd_left,
  output logic [W:0]    brd_right,
  output logic [W:0]    brd_top,
  output logic [W:0]    brd_bottom,
  output logic          o_valid,
  output logic          o_inside,
  output logic          o_fill_const,
  output logic [CW-1:0] o_rgb,
  output logic [W-1:0]  o_src_x,
  output logic [W-1:0]  o_src_y,
  output logic [W-1:0]  luma_x,
  output logic [W-1:0]  luma_y,
  output logic [W-1:0]  luma_w,
  output logic [W-1:0]  luma_h,
  output logic [W-1:0]  chroma_x,
  output logic [W-1:0]  chroma_y,
  output logic [W-1:0]  chroma_w,
  output logic [W-1:0]  chroma_h
);
  localparam int SW = W + 2;

  function automatic logic signed [SW-1:0] ext(input logic [W-1:0] v);
    return $signed({2'b00, v});
  endfunction

  function automatic logic signed [SW-1:0] clampc(input logic signed [SW-1:0] p,
                                                  input logic signed [SW-1:0] lo,
                                                  input logic signed [SW-1:0] hi);
    logic signed [SW-1:0] t;
    t = (p >= hi) ? hi - SW'(1) : p;
    if (t < lo) t = lo;
    return t;
  endfunction

  logic signed [SW-1:0] mg, r_raw, b_raw, x_end, y_end, cx, cy;
  logic in_x, in_y;

  assign mg    = dbg_margin ? SW'(2) : '0;
  assign r_raw = ext(act_w) - ext(rect_x) - ext(rect_w) + mg;
  assign b_raw = ext(act_h) - ext(rect_y) - ext(rect_h) + mg;

  assign brd_left   = {1'b0, rect_x};
  assign brd_top    = {1'b0, rect_y};
  assign brd_right  = (r_raw < 0) ? '0 : r_raw[W:0];
  assign brd_bottom = (b_raw < 0) ? '0 : b_raw[W:0];

  assign x_end = ext(act_w) - $signed({1'b0, brd_right});
  assign y_end = ext(act_h) - $signed({1'b0, brd_bottom});

  assign in_x = (ext(pix_x) >= ext(rect_x)) && (ext(pix_x) < x_end);
  assign in_y = (ext(pix_y) >= ext(rect_y)) && (ext(pix_y) < y_end);
  assign cx   = clampc(ext(pix_x), ext(rect_x), x_end);
  assign cy   = clampc(ext(pix_y), ext(rect_y), y_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid      <= 1'b0;
      o_inside     <= 1'b0;
      o_fill_const <= 1'b0;
      o_rgb        <= '0;
      o_src_x      <= '0;
      o_src_y      <= '0;
    end else begin
      o_valid      <= in_valid;
      o_inside     <= in_valid && in_x && in_y;
      o_fill_const <= in_valid && !(in_x && in_y) && !edge_mode;
      o_rgb        <= (in_valid && !(in_x && in_y) && !edge_mode) ? border_rgb : '0;
      o_src_x      <= cx[W-1:0];
      o_src_y      <= cy[W-1:0];
    end
  end

  logic [W-1:0] lx, ly, lw, lh;
  assign lx = {vp_x[W-1:1], 1'b0};
  assign ly = {vp_y[W-1:1], 1'b0};
  assign lw = {vp_w[W-1:1], 1'b0};
  assign lh = {vp_h[W-1:1], 1'b0};

  logic [W-1:0] ccx, ccy, ccw, cch;
  assign ccx = fmt420 ? lx >> 1 : lx;
  assign ccy = fmt420 ? ly >> 1 : ly;
  assign ccw = fmt420 ? lw >> 1 : lw;
  assign cch = fmt420 ? lh >> 1 : lh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      luma_x <= '0; luma_y <= '0; luma_w <= '0; luma_h <= '0;
      chroma_x <= '0; chroma_y <= '0; chroma_w <= '0; chroma_h <= '0;
    end else if (vp_load) begin
      if (lw != '0 && lh != '0) begin
        luma_x <= lx; luma_y <= ly; luma_w <= lw; luma_h <= lh;
      end
      if (ccw != '0 && cch != '0) begin
        chroma_x <= ccx; chroma_y <= ccy; chroma_w <= ccw; chroma_h <= cch;
      end
    end
  end

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> o_valid);
  assert_inside_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_inside) |-> (o_src_x == $past(pix_x) && o_src_y == $past(pix_y)));
  assert_fill_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({o_inside, o_fill_const}));
  assert_vp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !vp_load |=> ($stable(luma_w) && $stable(chroma_w) && $stable(luma_x)));
  assert_chroma_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_load && fmt420 && vp_w >= W'(4) && vp_h >= W'(4)) |=> (chroma_w == (luma_w >> 1)));
endmodule

// File: tb/sim_overscan_window.sv
module sim_overscan_window;
  localparam int W = 12;
  localparam int CW = 24;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] act_w, act_h, rect_x, rect_y, rect_w, rect_h;
  logic dbg_margin, edge_mode, in_valid, vp_load, fmt420;
  logic [CW-1:0] border_rgb;
  logic [W-1:0] pix_x, pix_y, vp_x, vp_y, vp_w, vp_h;
  logic [W:0] brd_left, brd_right, brd_top, brd_bottom;
  logic o_valid, o_inside, o_fill_const;
  logic [CW-1:0] o_rgb;
  logic [W-1:0] o_src_x, o_src_y, luma_x, luma_y, luma_w, luma_h;
  logic [W-1:0] chroma_x, chroma_y, chroma_w, chroma_h;

  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  overscan_window #(.W(W), .CW(CW)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pix(input int x, input int y, input logic v);
    @(negedge clk);
    pix_x = W'(x); pix_y = W'(y); in_valid = v;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic cfg_a();
    act_w = 100; act_h = 80; rect_x = 10; rect_y = 5; rect_w = 60; rect_h = 50;
    dbg_margin = 0;
  endtask

  task automatic t_reset();
    chk("R11 o_valid", o_valid, 0);
    chk("R11 o_inside", o_inside, 0);
    chk("R11 o_fill_const", o_fill_const, 0);
    chk("R11 o_rgb", o_rgb, 0);
    chk("R11 luma_w", luma_w, 0);
    chk("R11 chroma_h", chroma_h, 0);
  endtask

  task automatic t_borders();
    cfg_a(); #1;
    chk("R1 left", brd_left, 10);
    chk("R1 top", brd_top, 5);
    chk("R2 right", brd_right, 30);
    chk("R2 bottom", brd_bottom, 25);
    dbg_margin = 1; #1;
    chk("R4 right margin", brd_right, 32);
    chk("R4 bottom margin", brd_bottom, 27);
    dbg_margin = 0; rect_x = 50; rect_y = 40; #1;
    chk("R3 right clamp", brd_right, 0);
    chk("R3 bottom clamp", brd_bottom, 0);
  endtask

  task automatic t_const_fill();
    cfg_a(); edge_mode = 0; border_rgb = 24'h123456;
    pix(10, 5, 1);
    chk("R5 valid", o_valid, 1);
    chk("R5 inside corner", o_inside, 1);
    chk("R6 inside no fill", o_fill_const, 0);
    chk("R6 inside rgb", o_rgb, 0);
    chk("R7 inside src_x", o_src_x, 10);
    pix(69, 54, 1);
    chk("R5 inside far corner", o_inside, 1);
    pix(70, 54, 1);
    chk("R5 right edge out", o_inside, 0);
    chk("R6 const fill", o_fill_const, 1);
    chk("R6 border rgb", o_rgb, 24'h123456);
    pix(0, 0, 1);
    chk("R6 top-left fill", o_rgb, 24'h123456);
    pix(20, 20, 0);
    chk("R5 invalid", o_valid, 0);
    chk("R5 invalid not inside", o_inside, 0);
  endtask

  task automatic t_edge_repeat();
    cfg_a(); edge_mode = 1;
    pix(9, 5, 1);
    chk("R7 left out", o_inside, 0);
    chk("R7 no const fill", o_fill_const, 0);
    chk("R7 src_x left", o_src_x, 10);
    chk("R7 src_y", o_src_y, 5);
    pix(75, 60, 1);
    chk("R7 src_x right", o_src_x, 69);
    chk("R7 src_y bottom", o_src_y, 54);
    pix(30, 2, 1);
    chk("R7 src_x mid", o_src_x, 30);
    chk("R7 src_y top", o_src_y, 5);
  endtask

  task automatic t_margin_clamp();
    cfg_a(); edge_mode = 0; dbg_margin = 1;
    pix(67, 20, 1);
    chk("R4 inside before margin", o_inside, 1);
    pix(68, 20, 1);
    chk("R4 margin column out", o_inside, 0);
    dbg_margin = 0; rect_x = 50; rect_w = 60;
    pix(99, 20, 1);
    chk("R3 clamped edge inside", o_inside, 1);
  endtask

  task automatic t_viewport();
    @(negedge clk);
    vp_x = 7; vp_y = 5; vp_w = 33; vp_h = 21; fmt420 = 0; vp_load = 1;
    @(negedge clk); vp_load = 0;
    chk("R8 luma_x", luma_x, 6);
    chk("R8 luma_y", luma_y, 4);
    chk("R8 luma_w", luma_w, 32);
    chk("R8 luma_h", luma_h, 20);
    chk("R9 chroma eq w", chroma_w, 32);
    chk("R9 chroma eq x", chroma_x, 6);
    vp_load = 1; fmt420 = 1;
    @(negedge clk); vp_load = 0;
    chk("R9 chroma x", chroma_x, 3);
    chk("R9 chroma y", chroma_y, 2);
    chk("R9 chroma w", chroma_w, 16);
    chk("R9 chroma h", chroma_h, 10);
    vp_x = 40; vp_w = 1; vp_load = 1;
    @(negedge clk); vp_load = 0;
    chk("R10 luma_w held", luma_w, 32);
    chk("R10 luma_x held", luma_x, 6);
    chk("R10 chroma_w held", chroma_w, 16);
  endtask

  initial begin
    in_valid = 0; vp_load = 0; fmt420 = 0; edge_mode = 0; dbg_margin = 0;
    border_rgb = 0; pix_x = 0; pix_y = 0; vp_x = 0; vp_y = 0; vp_w = 0; vp_h = 0;
    cfg_a();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_borders();
    t_const_fill();
    t_edge_repeat();
    t_margin_clamp();
    t_viewport();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #1000000;
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule